// File: doc/BRIEF.md
# LED Backlight Fault Supervisor

This block is the digital protection controller for a six-string LED backlight boost driver. The analog comparators outside it report undervoltage, output overvoltage, inductor overcurrent, overtemperature and, for each string, a zero-current condition. The block combines these flags with the enable pin, a strobe that marks the start of each switching period and a configuration bit that arms overcurrent shutdown. From them it produces three registered outputs: permission for the power switch gate, a mask of the strings still in regulation, and a global shutdown.

The block handles two kinds of fault. Some faults hold only while their flag is present and clear by themselves: overvoltage, overtemperature and undervoltage. Other faults are latched and clear only on reset or when enable is taken low: a string found open, all strings open, and overcurrent that lasts too long. On top of these, a current-limit blanking turns the gate off for the rest of the current switching period. The time for sustained overcurrent is a counter whose length comes from the clock frequency parameter.

Top module: `led_fault_supervisor`

## Requirements
- R1: While reset is held, gate_allow_o is 0, shutdown_o is 1 and chan_mask_o is all ones.
- R2: With enable high and no flags, gate_allow_o is 1 and shutdown_o is 0 after the next rising clock edge. All outputs are registered and follow their inputs one edge later.
- R3: An overcurrent flag forces gate_allow_o to 0 from the next edge. The gate stays off until a cycle in which cycle_start_i is 1 and the overcurrent flag is 0. If the flag and the strobe arrive in the same cycle, the flag wins.
- R4: The overvoltage flag drops gate_allow_o only while it is asserted. It never asserts shutdown_o and leaves nothing latched.
- R5: Overtemperature asserts shutdown_o and clears gate_allow_o while present. Operation resumes by itself when the flag clears.
- R6: Undervoltage asserts shutdown_o while present and holds back start-up until it clears.
- R7: Bit k of chan_mask_o (bit 0 = first string) is cleared only when the device is running, the overvoltage flag is set and bit k of zero_cur_i is set. A zero-current bit alone removes nothing.
- R8: A removed string stays removed after its current returns. Taking enable low restores all mask bits to 1.
- R9: When every mask bit is 0, shutdown_o is 1. It stays 1 until enable is taken low.
- R10: With oc_shdn_en_i = 1, overcurrent present for more than CLK_FREQ_KHZ*OC_TRIP_MS consecutive cycles latches shutdown_o on the edge after cycle number limit+1. The latch clears only when enable is taken low or on reset.
- R11: Any cycle without overcurrent restarts the sustained-overcurrent count from zero.
- R12: With oc_shdn_en_i = 0 (its default), sustained overcurrent never asserts shutdown_o. It only blanks the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| enable_i | input | 1 | Device enable; low clears all latched faults |
| uv_flag_i | input | 1 | Supply undervoltage flag |
| ov_flag_i | input | 1 | Output overvoltage flag |
| oc_flag_i | input | 1 | Inductor overcurrent flag |
| ot_flag_i | input | 1 | Overtemperature flag |
| zero_cur_i | input | NUM_CH | Per-string zero-current flags |
| cycle_start_i | input | 1 | Switching period start strobe |
| oc_shdn_en_i | input | 1 | Arms the sustained-overcurrent shutdown |
| gate_allow_o | output | 1 | Power switch may be turned on |
| chan_mask_o | output | NUM_CH | Strings still in regulation |
| shutdown_o | output | 1 | Global shutdown |

## Verification
Every result is due one rising edge after the stimulus that causes it. Each output is a single register fed from the current inputs and the next state of the sub-blocks. The bench changes inputs just after a falling edge and samples outputs 2 ns after the following rising edge, so each vector row checks exactly the edge it caused. The sustained-overcurrent trip is checked on both sides of its boundary. After limit cycles shutdown must still be low, and after limit+1 cycles it must be high.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    // Snapshot of the single-bit protection inputs
    typedef struct packed {
        logic en;
        logic uv;
        logic ov;
        logic oc;
        logic ot;
    } flags_t;

    // Width of a counter that must hold values 0..lim
    function automatic int cnt_width(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/lfs_oc_guard.sv
module lfs_oc_guard #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic oc_i,
    input  logic cyc_start_i,
    input  logic shdn_en_i,
    output logic blank_nxt_o,
    output logic trip_nxt_o
);
    localparam int CW = lfs_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    typedef struct packed {
        logic          blank;
        logic          trip;
        logic [CW-1:0] cnt;
    } oc_st_t;

    oc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.blank = 1'b0;
            st_d.trip  = 1'b0;
            st_d.cnt   = '0;
        end else begin
            // current limit blanks the switch for the rest of the period
            if (oc_i)
                st_d.blank = 1'b1;
            else if (cyc_start_i)
                st_d.blank = 1'b0;
            // consecutive overcurrent cycles, saturating at the limit
            if (!oc_i)
                st_d.cnt = '0;
            else if (st_q.cnt != LIM_V)
                st_d.cnt = st_q.cnt + 1'b1;
            if (oc_i && shdn_en_i && (st_q.cnt == LIM_V))
                st_d.trip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign blank_nxt_o = st_d.blank;
    assign trip_nxt_o  = st_d.trip;

    // R3: blanking holds until a period start arrives
    p_blank_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blank && !cyc_start_i && en_i) |=> st_q.blank);

    // R10: the trip latch is sticky while enabled
    p_trip_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trip && en_i) |=> st_q.trip);

    // R11: a quiet cycle empties the counter
    p_cnt_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc_i) |=> (st_q.cnt == '0));

    // R12: no trip can appear while shutdown is not armed
    p_no_trip_unarmed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.trip && !shdn_en_i) |=> !st_q.trip);

endmodule

// File: rtl/lfs_open_track.sv
module lfs_open_track #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              eval_i,
    input  logic [NUM_CH-1:0] zero_i,
    output logic [NUM_CH-1:0] mask_nxt_o
);
    logic [NUM_CH-1:0] mask_d, mask_q;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        always_comb begin
            if (!en_i)
                mask_d[k] = 1'b1;
            else if (eval_i && zero_i[k])
                mask_d[k] = 1'b0;
            else
                mask_d[k] = mask_q[k];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[k] <= 1'b1;
            else
                mask_q[k] <= mask_d[k];
        end
    end

    assign mask_nxt_o = mask_d;

    // R8: while enabled, no string is ever put back
    p_mask_no_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((mask_q | $past(mask_q)) == $past(mask_q)));

    // R7: without evaluation nothing is removed
    p_mask_needs_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_i) |=> ($countones(mask_q) >= $countones($past(mask_q))));

endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor #(
    parameter int NUM_CH       = 6,
    parameter int CLK_FREQ_KHZ = 100000,
    parameter int OC_TRIP_MS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              uv_flag_i,
    input  logic              ov_flag_i,
    input  logic              oc_flag_i,
    input  logic              ot_flag_i,
    input  logic [NUM_CH-1:0] zero_cur_i,
    input  logic              cycle_start_i,
    input  logic              oc_shdn_en_i,
    output logic              gate_allow_o,
    output logic [NUM_CH-1:0] chan_mask_o,
    output logic              shutdown_o
);
    import lfs_pkg::*;

    localparam int OC_LIMIT = CLK_FREQ_KHZ * OC_TRIP_MS;

    typedef struct packed {
        logic gate;
        logic shdn;
    } out_st_t;

    flags_t            fl;
    out_st_t           out_d, out_q;
    logic              blank_nxt, trip_nxt, eval_open;
    logic [NUM_CH-1:0] mask_nxt, mask_q;

    assign fl = '{en: enable_i, uv: uv_flag_i, ov: ov_flag_i,
                  oc: oc_flag_i, ot: ot_flag_i};

    // open strings are judged only when running and the output hit its ceiling
    assign eval_open = fl.en && fl.ov && !out_q.shdn;

    lfs_oc_guard #(.LIMIT(OC_LIMIT)) u_oc (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (fl.en),
        .oc_i        (fl.oc),
        .cyc_start_i (cycle_start_i),
        .shdn_en_i   (oc_shdn_en_i),
        .blank_nxt_o (blank_nxt),
        .trip_nxt_o  (trip_nxt)
    );

    lfs_open_track #(.NUM_CH(NUM_CH)) u_open (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (fl.en),
        .eval_i     (eval_open),
        .zero_i     (zero_cur_i),
        .mask_nxt_o (mask_nxt)
    );

    always_comb begin
        out_d.shdn = !fl.en || fl.uv || fl.ot || trip_nxt || (mask_nxt == '0);
        out_d.gate = !out_d.shdn && !fl.ov && !blank_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '{gate: 1'b0, shdn: 1'b1};
            mask_q <= '1;
        end else begin
            out_q  <= out_d;
            mask_q <= mask_nxt;
        end
    end

    assign gate_allow_o = out_q.gate;
    assign shutdown_o   = out_q.shdn;
    assign chan_mask_o  = mask_q;

    // R9: an empty mask always coincides with shutdown
    p_all_open_shdn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mask_o == '0) |-> shutdown_o);

    // R5: the gate is never allowed during shutdown
    p_gate_off_in_shdn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !gate_allow_o);

    // R4: overvoltage alone never causes shutdown
    p_ov_no_shdn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !uv_flag_i && !ot_flag_i && !oc_flag_i && ov_flag_i
         && !shutdown_o && (zero_cur_i == '0)) |=> (!shutdown_o && !gate_allow_o));

    // R6: undervoltage forces shutdown on the next edge
    p_uv_shdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag_i |=> shutdown_o);

endmodule

// File: tb/sim_led_fault_supervisor.sv
module sim_led_fault_supervisor;
    localparam int NCH   = 6;
    localparam int KHZ   = 10;
    localparam int TMS   = 2;
    localparam int LIMIT = KHZ * TMS;
    localparam int NVEC  = 21;

    // row: {en,uv,ov,oc,ot,cs} {zero_cur} {gate,shdn} {mask}
    localparam logic [19:0] VEC [NVEC] = '{
        {6'b100000, 6'h00, 2'b10, 6'h3F},  // R2 normal run
        {6'b110000, 6'h00, 2'b01, 6'h3F},  // R6 undervoltage
        {6'b100000, 6'h00, 2'b10, 6'h3F},  // R6 released
        {6'b100010, 6'h00, 2'b01, 6'h3F},  // R5 overtemperature
        {6'b100000, 6'h00, 2'b10, 6'h3F},  // R5 auto restart
        {6'b101000, 6'h00, 2'b00, 6'h3F},  // R4 overvoltage inhibits gate
        {6'b100000, 6'h00, 2'b10, 6'h3F},  // R4 resumes
        {6'b100000, 6'h04, 2'b10, 6'h3F},  // R7 zero current alone ignored
        {6'b101000, 6'h04, 2'b00, 6'h3B},  // R7 removed at overvoltage
        {6'b100000, 6'h00, 2'b10, 6'h3B},  // R8 stays removed
        {6'b100100, 6'h00, 2'b00, 6'h3B},  // R3 limit blanks
        {6'b100000, 6'h00, 2'b00, 6'h3B},  // R3 still blanked
        {6'b100001, 6'h00, 2'b10, 6'h3B},  // R3 period start releases
        {6'b100101, 6'h00, 2'b00, 6'h3B},  // R3 flag beats strobe
        {6'b100001, 6'h00, 2'b10, 6'h3B},  // R3 release
        {6'b000000, 6'h00, 2'b01, 6'h3F},  // R8 enable low restores
        {6'b100000, 6'h00, 2'b10, 6'h3F},  // R8 running again
        {6'b101000, 6'h3F, 2'b01, 6'h00},  // R9 all open
        {6'b100000, 6'h00, 2'b01, 6'h00},  // R9 latched
        {6'b000000, 6'h00, 2'b01, 6'h3F},  // R9 toggle low
        {6'b100000, 6'h00, 2'b10, 6'h3F}   // R9 recovered
    };
    localparam int VREQ [NVEC] = '{2,6,6,5,5,4,4,7,7,8,3,3,3,3,3,8,8,9,9,9,9};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0, uv = 1'b0, ov = 1'b0, oc = 1'b0, ot = 1'b0, cs = 1'b0;
    logic           shen = 1'b0;
    logic [NCH-1:0] zc = '0;
    logic           gate, shdn;
    logic [NCH-1:0] mask;
    int             n_chk = 0;
    int             n_bad = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    led_fault_supervisor #(.NUM_CH(NCH), .CLK_FREQ_KHZ(KHZ), .OC_TRIP_MS(TMS)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .uv_flag_i(uv), .ov_flag_i(ov),
        .oc_flag_i(oc), .ot_flag_i(ot), .zero_cur_i(zc), .cycle_start_i(cs),
        .oc_shdn_en_i(shen), .gate_allow_o(gate), .chan_mask_o(mask), .shutdown_o(shdn)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got {gate,shdn,mask}=%b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic [5:0] ctl, input logic [NCH-1:0] z);
        @(negedge clk);
        {en, uv, ov, oc, ot, cs} = ctl;
        zc = z;
        @(posedge clk);
        #2;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", {gate, shdn, mask}, {2'b01, 6'h3F});
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][19:14], VEC[i][13:8]);
            check($sformatf("R%0d row %0d", VREQ[i], i), {gate, shdn, mask}, VEC[i][7:0]);
        end

        // R12 sustained overcurrent with shutdown disarmed
        for (int i = 0; i < 2 * LIMIT; i++) step(6'b100100, '0);
        check("R12", {gate, shdn, mask}, {2'b00, 6'h3F});
        step(6'b100001, '0);
        check("R12 release", {gate, shdn, mask}, {2'b10, 6'h3F});

        // R11 a gap restarts the count
        shen = 1'b1;
        for (int i = 0; i < LIMIT; i++) step(6'b100100, '0);
        step(6'b100000, '0);
        for (int i = 0; i < LIMIT; i++) step(6'b100100, '0);
        check("R11", {gate, shdn, mask}, {2'b00, 6'h3F});

        // R10 one more overcurrent cycle passes the limit
        step(6'b100100, '0);
        check("R10 trip", {gate, shdn, mask}, {2'b01, 6'h3F});
        step(6'b100001, '0);
        check("R10 latched", {gate, shdn, mask}, {2'b01, 6'h3F});
        step(6'b000000, '0);
        step(6'b100000, '0);
        check("R10 cleared", {gate, shdn, mask}, {2'b10, 6'h3F});

        done = 1'b1;
        report();
    end
endmodule